// File: doc/BRIEF.md
# Boot-Time Serial EEPROM Reader

This block runs one read transaction right after power-on reset. It fetches three 16-bit configuration words from a serial EEPROM that is organised as 16-bit words and that advances its own address. The EEPROM's data input and data output are tied together, so one bidirectional data line carries both directions. The block divides the system clock to make the serial clock. It drives the start bit, the read opcode and a word address of all zeros onto the data line, and then hands the line over to the EEPROM. It then collects 48 data bits and turns them into a ganged power-mode flag, a vendor identifier and a product identifier.

An active-low enable strap turns the interface off. When the strap is high, neither the serial clock nor the data line is ever driven. The data pin is then read as the ganged-mode strap, and the two identifiers take default values set by parameters. After the read, or right away in the disabled case, both outputs go to high impedance and stay there, so that other logic can use the EEPROM. A one-cycle done pulse marks the moment the decoded values become valid.

Top module: `boot_eeprom_reader`

## Requirements
- R1: While reset is asserted, `sclk_oe`, `sdat_oe` and `done_o` are low, and `ganged_o`, `vendor_id_o` and `product_id_o` are zero. The decoded outputs stay zero until `done_o` pulses.
- R2: When `mem_en_n` is low at the first clock after reset, `sclk_oe` goes high. `sclk_o` starts low and toggles so that each period lasts `CLK_DIV` system cycles, half low and half high. Exactly 57 rising edges are produced.
- R3: During the first nine serial clock periods, the block drives the bits 1, 1, 0, 0, 0, 0, 0, 0, 0 onto the data line in that order. These are the start bit, the opcode 1,0 and six address zeros. Each bit is valid before its rising edge.
- R4: The block releases the data line (`sdat_oe` falls) during the high phase of the ninth period, right after the ninth rising edge. From then on it never drives the line, so the EEPROM can present its dummy 0 bit without contention.
- R5: The data bits are sampled on the falling edges of periods 10 to 57, most significant bit first. The first word received is word 0, then word 1, then word 2. The dummy bit is not stored.
- R6: `ganged_o` equals bit 14 of word 0, and the other bits of word 0 are ignored. `vendor_id_o` equals word 1, with the high byte in bits 15..8. `product_id_o` equals word 2, with the same byte layout.
- R7: After the 57th falling edge, `sclk_oe` and `sdat_oe` are low and no further serial clock edges occur. `sdat_oe` is never high while `sclk_oe` is low.
- R8: `done_o` is high for exactly one cycle. The decoded outputs take their new values in that same cycle and then hold them until the next reset.
- R9: When `mem_en_n` is high at the first clock after reset, `sclk_oe` and `sdat_oe` never assert. In that case `vendor_id_o` = `DEF_VID`, `product_id_o` = `DEF_PID`, `ganged_o` equals the value on `sdat_i`, and `done_o` pulses in the second cycle after reset is released.
- R10: The read happens only once per reset. Changing `mem_en_n` after `done_o` starts no new transaction and leaves the outputs unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset (power-on) |
| mem_en_n | input | 1 | Active-low enable strap for the EEPROM interface |
| sdat_i | input | 1 | Value sensed on the shared data line (ganged strap when disabled) |
| sclk_o | output | 1 | Serial clock value |
| sclk_oe | output | 1 | Output enable of the serial clock pad |
| sdat_o | output | 1 | Value driven onto the data line |
| sdat_oe | output | 1 | Output enable of the data line pad |
| ganged_o | output | 1 | Ganged power-management flag |
| vendor_id_o | output | 16 | Decoded vendor identifier |
| product_id_o | output | 16 | Decoded product identifier |
| done_o | output | 1 | One-cycle pulse when the decoded values are valid |

## Verification
The assertions assume the following: the strap and the data pin stay steady from reset until `done_o`; the EEPROM changes the data line only right after a serial clock rising edge; and it starts to drive the line only after the ninth rising edge. `CLK_DIV` is assumed to be even and at least 4. The bench's EEPROM responder follows these rules. It drives the dummy bit at the ninth rising edge and each data bit at the following rising edges, and it stops driving at `done_o`. The straps are set while reset is asserted and are changed only after `done_o`, which is the window that exercises R10.

// File: rtl/eerd_pkg.sv
package eerd_pkg;

  typedef enum logic [1:0] {
    PH_BOOT = 2'd0,
    PH_READ = 2'd1,
    PH_HOLD = 2'd2
  } eerd_phase_t;

  // Command bit for serial period idx: start 1, opcode 1 0, then address zeros.
  function automatic logic cmd_bit(input int unsigned idx);
    return (idx < 2);
  endfunction

  // Word k of the received 48-bit stream; word 0 arrived first.
  function automatic logic [15:0] word_at(input logic [47:0] s, input int unsigned k);
    if (k == 0) return s[47:32];
    if (k == 1) return s[31:16];
    return s[15:0];
  endfunction

  // Ganged flag lives in bit 14 of word 0.
  function automatic logic gang_of(input logic [15:0] w0);
    return w0[14];
  endfunction

endpackage

// File: rtl/eerd_clkgen.sv
module eerd_clkgen #(
  parameter int DIV = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic sclk,
  output logic rise_tk,
  output logic fall_tk
);
  localparam int HALF = DIV / 2;
  localparam int CW   = $clog2(DIV);

  logic [CW-1:0] cnt;

  assign rise_tk = run && (cnt == CW'(HALF - 1));
  assign fall_tk = run && (cnt == CW'(DIV - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt  <= '0;
      sclk <= 1'b0;
    end else if (!run) begin
      cnt  <= '0;
      sclk <= 1'b0;
    end else begin
      cnt <= (cnt == CW'(DIV - 1)) ? '0 : cnt + 1'b1;
      if (rise_tk)      sclk <= 1'b1;
      else if (fall_tk) sclk <= 1'b0;
    end
  end

  assert_fall_from_high_R2: assert property (@(posedge clk) disable iff (!rst_n)
    fall_tk |-> sclk);
  assert_rise_from_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rise_tk |-> !sclk);
  assert_idle_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> !sclk);

endmodule

// File: rtl/eerd_seq.sv
module eerd_seq
  import eerd_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        mem_en_n,
  input  logic        sdat_i,
  input  logic        sclk,
  input  logic        fall_tk,
  output logic        run,
  output logic        sclk_oe,
  output logic        sdat_o,
  output logic        sdat_oe,
  output logic        fire,
  output logic        skip,
  output logic        strap,
  output logic [47:0] stream,
  output logic        off_mode
);
  localparam int CMD_LEN  = 3 + ADDR_W;
  localparam int DATA_LEN = 48;
  localparam int TOTAL    = CMD_LEN + DATA_LEN;
  localparam int BW       = $clog2(TOTAL + 1);

  eerd_phase_t         phase;
  logic [BW-1:0]       bitn;
  logic [DATA_LEN-1:0] shreg;
  logic                last_fall;
  logic                in_data;

  assign run       = (phase == PH_READ);
  assign sclk_oe   = run;
  assign last_fall = run && fall_tk && (bitn == BW'(TOTAL - 1));
  assign in_data   = (bitn >= BW'(CMD_LEN));
  assign fire      = last_fall;
  assign skip      = (phase == PH_BOOT) && mem_en_n;
  assign strap     = sdat_i;
  assign stream    = {shreg[DATA_LEN-2:0], sdat_i};

  // Controller owns the line until the last command rising edge has passed.
  assign sdat_oe = run && ((bitn < BW'(CMD_LEN - 1)) ||
                           ((bitn == BW'(CMD_LEN - 1)) && !sclk));
  assign sdat_o  = sdat_oe && cmd_bit(int'(bitn));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase    <= PH_BOOT;
      bitn     <= '0;
      shreg    <= '0;
      off_mode <= 1'b0;
    end else begin
      case (phase)
        PH_BOOT: begin
          if (mem_en_n) begin
            phase    <= PH_HOLD;
            off_mode <= 1'b1;
          end else begin
            phase <= PH_READ;
          end
        end
        PH_READ: begin
          if (fall_tk) begin
            bitn <= bitn + 1'b1;
            if (in_data) shreg <= {shreg[DATA_LEN-2:0], sdat_i};
            if (last_fall) phase <= PH_HOLD;
          end
        end
        default: phase <= PH_HOLD;
      endcase
    end
  end

  assert_release_in_high_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sdat_oe) |-> sclk);
  assert_data_needs_clock_R7: assert property (@(posedge clk) disable iff (!rst_n)
    sdat_oe |-> sclk_oe);
  assert_single_read_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_HOLD) |=> (phase == PH_HOLD) && !sclk_oe);
  assert_off_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    off_mode |-> !sclk_oe && !sdat_oe);

endmodule

// File: rtl/eerd_decode.sv
module eerd_decode
  import eerd_pkg::*;
#(
  parameter logic [15:0] DEF_VID = 16'hC0DE,
  parameter logic [15:0] DEF_PID = 16'h4B1D
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        fire,
  input  logic        skip,
  input  logic        strap,
  input  logic [47:0] stream,
  output logic        ganged,
  output logic [15:0] vid,
  output logic [15:0] pid,
  output logic        done,
  output logic        held
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ganged <= 1'b0;
      vid    <= '0;
      pid    <= '0;
      done   <= 1'b0;
      held   <= 1'b0;
    end else begin
      done <= 1'b0;
      if (fire) begin
        ganged <= gang_of(word_at(stream, 0));
        vid    <= word_at(stream, 1);
        pid    <= word_at(stream, 2);
        done   <= 1'b1;
        held   <= 1'b1;
      end else if (skip) begin
        ganged <= strap;
        vid    <= DEF_VID;
        pid    <= DEF_PID;
        done   <= 1'b1;
        held   <= 1'b1;
      end
    end
  end

  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  assert_hold_values_R8: assert property (@(posedge clk) disable iff (!rst_n)
    held |=> $stable(vid) && $stable(pid) && $stable(ganged));
  assert_no_second_load_R10: assert property (@(posedge clk) disable iff (!rst_n)
    held |-> !fire && !skip);
  assert_zero_until_done_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !held |-> (vid == 16'h0) && (pid == 16'h0) && !ganged);

endmodule

// File: rtl/boot_eeprom_reader.sv
module boot_eeprom_reader
  import eerd_pkg::*;
#(
  parameter int          CLK_DIV = 16,
  parameter int          ADDR_W  = 6,
  parameter logic [15:0] DEF_VID = 16'hC0DE,
  parameter logic [15:0] DEF_PID = 16'h4B1D
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        mem_en_n,
  input  logic        sdat_i,
  output logic        sclk_o,
  output logic        sclk_oe,
  output logic        sdat_o,
  output logic        sdat_oe,
  output logic        ganged_o,
  output logic [15:0] vendor_id_o,
  output logic [15:0] product_id_o,
  output logic        done_o
);
  logic        run;
  logic        sclk;
  logic        rise_tk;
  logic        fall_tk;
  logic        fire;
  logic        skip;
  logic        strap;
  logic [47:0] stream;
  logic        off_mode;
  logic        held;

  eerd_clkgen #(.DIV(CLK_DIV)) u_clk (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (run),
    .sclk    (sclk),
    .rise_tk (rise_tk),
    .fall_tk (fall_tk)
  );

  eerd_seq #(.ADDR_W(ADDR_W)) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .mem_en_n (mem_en_n),
    .sdat_i   (sdat_i),
    .sclk     (sclk),
    .fall_tk  (fall_tk),
    .run      (run),
    .sclk_oe  (sclk_oe),
    .sdat_o   (sdat_o),
    .sdat_oe  (sdat_oe),
    .fire     (fire),
    .skip     (skip),
    .strap    (strap),
    .stream   (stream),
    .off_mode (off_mode)
  );

  eerd_decode #(.DEF_VID(DEF_VID), .DEF_PID(DEF_PID)) u_dec (
    .clk    (clk),
    .rst_n  (rst_n),
    .fire   (fire),
    .skip   (skip),
    .strap  (strap),
    .stream (stream),
    .ganged (ganged_o),
    .vid    (vendor_id_o),
    .pid    (product_id_o),
    .done   (done_o),
    .held   (held)
  );

  assign sclk_o = sclk;

  assert_edges_exclusive_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !(rise_tk && fall_tk));
  assert_clock_off_after_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
    held |-> !sclk_oe && !sdat_oe);

endmodule

// File: tb/tb_boot_eeprom_reader.sv
module tb_boot_eeprom_reader;
  localparam int          CLK_PERIOD = 10;
  localparam int          DIV        = 16;
  localparam int          HALF       = DIV / 2;
  localparam int          CMD_LEN    = 9;
  localparam int          NRISE      = 57;
  localparam logic [15:0] DVID       = 16'hC0DE;
  localparam logic [15:0] DPID       = 16'h4B1D;

  typedef struct packed {
    logic        en_n;
    logic        strap;
    logic [15:0] w0, w1, w2;
    logic        exp_g;
    logic [15:0] exp_vid, exp_pid;
  } vec_t;

  localparam int NV = 6;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 1'b0, 16'h4000, 16'h1234, 16'hABCD, 1'b1, 16'h1234, 16'hABCD},
    '{1'b0, 1'b0, 16'h0000, 16'hFFFF, 16'h0001, 1'b0, 16'hFFFF, 16'h0001},
    '{1'b0, 1'b0, 16'hBFFF, 16'h8000, 16'h7FFE, 1'b0, 16'h8000, 16'h7FFE},
    '{1'b0, 1'b0, 16'h7FFF, 16'h5AA5, 16'hA55A, 1'b1, 16'h5AA5, 16'hA55A},
    '{1'b1, 1'b1, 16'h0000, 16'h1111, 16'h2222, 1'b1, DVID,     DPID},
    '{1'b1, 1'b0, 16'h4000, 16'h3333, 16'h4444, 1'b0, DVID,     DPID}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic mem_en_n = 1'b0;
  logic strap = 1'b0;
  logic [47:0] stream = '0;
  logic sdat_line;
  logic sclk_o, sclk_oe, sdat_o, sdat_oe, ganged_o, done_o;
  logic [15:0] vendor_id_o, product_id_o;

  int checks = 0;
  int errors = 0;

  // monitor / responder state
  int   cyc = 0;
  int   rises, last_rise, per_err, cmd_oe_err, contention, oe_fall_at;
  int   done_cnt, done_long, done_cyc, early_err, after_err, chg_err, oe_seen;
  logic [8:0]  cmd_cap;
  logic        oe_fall_hi, ee_drv, ee_bit, done_seen;
  logic        prev_sclk, prev_o, prev_oe, prev_done;
  logic        got_g;
  logic [15:0] got_vid, got_pid;

  always #(CLK_PERIOD/2) clk = ~clk;

  assign sdat_line = sdat_oe ? sdat_o : (ee_drv ? ee_bit : strap);

  boot_eeprom_reader #(.CLK_DIV(DIV), .DEF_VID(DVID), .DEF_PID(DPID)) dut (
    .clk          (clk),
    .rst_n        (rst_n),
    .mem_en_n     (mem_en_n),
    .sdat_i       (sdat_line),
    .sclk_o       (sclk_o),
    .sclk_oe      (sclk_oe),
    .sdat_o       (sdat_o),
    .sdat_oe      (sdat_oe),
    .ganged_o     (ganged_o),
    .vendor_id_o  (vendor_id_o),
    .product_id_o (product_id_o),
    .done_o       (done_o)
  );

  always @(negedge clk) begin
    logic sk;
    cyc++;
    sk = sclk_o && sclk_oe;
    if (!rst_n) begin
      rises = 0; last_rise = 0; per_err = 0; cmd_oe_err = 0; contention = 0;
      oe_fall_at = -1; oe_fall_hi = 1'b0; done_cnt = 0; done_long = 0; done_cyc = -1;
      early_err = 0; after_err = 0; chg_err = 0; oe_seen = 0; cmd_cap = '0;
      ee_drv = 1'b0; ee_bit = 1'b0; done_seen = 1'b0;
      prev_sclk = 1'b0; prev_o = 1'b0; prev_oe = 1'b0; prev_done = 1'b0;
      got_g = 1'b0; got_vid = '0; got_pid = '0;
    end else begin
      if (sk && !prev_sclk) begin
        if (rises > 0 && cyc - last_rise != DIV) per_err++;
        last_rise = cyc;
        if (rises < CMD_LEN) begin
          cmd_cap = {cmd_cap[7:0], prev_o};
          if (!prev_oe) cmd_oe_err++;
        end
        if (rises >= CMD_LEN - 1) begin
          ee_drv = 1'b1;
          if (rises == CMD_LEN - 1)  ee_bit = 1'b0;
          else if (rises < NRISE)    ee_bit = stream[56 - rises];
          else                       ee_bit = 1'b0;
        end
        rises++;
      end
      if (prev_sclk && !sk && cyc - last_rise != HALF) per_err++;
      if (sdat_oe && ee_drv) contention++;
      if (prev_oe && !sdat_oe) begin
        oe_fall_at = rises;
        oe_fall_hi = sk;
      end
      if (done_o) begin
        done_cnt++;
        if (prev_done) done_long++;
        got_g = ganged_o; got_vid = vendor_id_o; got_pid = product_id_o;
        done_seen = 1'b1; done_cyc = cyc; ee_drv = 1'b0;
      end else if (done_seen) begin
        if (sclk_oe || sdat_oe) after_err++;
        if (ganged_o != got_g || vendor_id_o != got_vid || product_id_o != got_pid) chg_err++;
      end
      if (!done_seen && (ganged_o || vendor_id_o != 0 || product_id_o != 0)) early_err++;
      if (sclk_oe || sdat_oe) oe_seen++;
      prev_sclk = sk; prev_o = sdat_o; prev_oe = sdat_oe; prev_done = done_o;
    end
  end

  task automatic chk(input logic ok, input string tag, input logic [63:0] act,
                     input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    for (int v = 0; v < NV; v++) begin
      vec_t t;
      int rel_cyc;
      t = VECS[v];
      @(posedge clk); #1;
      rst_n = 1'b0;
      mem_en_n = t.en_n;
      strap = t.strap;
      stream = {t.w0, t.w1, t.w2};
      repeat (3) @(posedge clk);
      #1;
      // R1: reset state
      chk(!sclk_oe && !sdat_oe && !done_o, "R1 reset enables/done", {sclk_oe, sdat_oe, done_o}, 0);
      chk(vendor_id_o == 0 && product_id_o == 0 && !ganged_o, "R1 reset outputs",
          {ganged_o, vendor_id_o, product_id_o}, 0);
      rst_n = 1'b1;
      rel_cyc = cyc;
      for (int w = 0; w < 2000 && !done_seen; w++) @(posedge clk);
      repeat (2 * DIV) @(posedge clk);
      #1 mem_en_n = ~mem_en_n;   // R10: strap change after done
      repeat (3 * DIV) @(posedge clk);
      #1;
      chk(done_cnt == 1 && done_long == 0, "R8 done single pulse", {done_cnt, done_long}, 1 << 32);
      chk(early_err == 0 && chg_err == 0, "R8 outputs hold", {early_err, chg_err}, 0);
      chk(got_g == t.exp_g, "R6 ganged flag", got_g, t.exp_g);
      chk(got_vid == t.exp_vid, "R6 vendor id", got_vid, t.exp_vid);
      chk(got_pid == t.exp_pid, "R5 product id", got_pid, t.exp_pid);
      chk(after_err == 0, "R10 no activity after done", after_err, 0);
      if (!t.en_n) begin
        chk(rises == NRISE, "R2 rising edge count", rises, NRISE);
        chk(per_err == 0, "R2 clock period/duty", per_err, 0);
        chk(cmd_cap == 9'b110000000, "R3 command bits", cmd_cap, 9'b110000000);
        chk(cmd_oe_err == 0, "R3 command driven", cmd_oe_err, 0);
        chk(oe_fall_at == CMD_LEN && oe_fall_hi, "R4 handover point",
            {oe_fall_hi, 32'(oe_fall_at)}, {1'b1, 32'(CMD_LEN)});
        chk(contention == 0, "R4 no contention", contention, 0);
        chk(!sclk_oe && !sdat_oe && !sclk_o, "R7 released after read",
            {sclk_oe, sdat_oe, sclk_o}, 0);
      end else begin
        chk(oe_seen == 0, "R9 pads never driven", oe_seen, 0);
        chk(done_cyc == rel_cyc + 2, "R9 done timing", done_cyc, rel_cyc + 2);
      end
    end
    finish_run();
  end

endmodule